// File: doc/BRIEF.md
# SMBus Configuration-Recovery Command Responder

This block is an SMBus target that listens for one command, which unlocks a device whose non-volatile configuration image is corrupt. It answers at a single fixed target address and decodes a Write Data Byte transaction made of three bytes: the address with the write bit, a command code and a data byte. The block samples SCL and SDA through synchronisers. It acknowledges a byte by pulling SDA low, through an open-drain drive output.

The command is honoured only inside a power-management window. A link reset opens the window, and it stays open while every function is still in the uninitialised full-power state. The window closes as soon as any function becomes active. It then stays closed until the next link reset, even if a function drops back to the uninitialised state. A stop condition that ends a fully acknowledged command starts an update of the configuration signature word in an attached word-addressed memory. The update reads the word once, then writes it back once with its two top bits cleared. The block never resets the device on its own. A clock-gate request output tells the surrounding logic that the responder has no more work to do.

Top module: `smbus_recovery_responder`

## Requirements
- R1: The address byte is acknowledged only when it equals C8h: the 7-bit target address 64h followed by write bit 0. Any other address byte, including C9h (read), is not acknowledged, and nothing is written.
- R2: After an acknowledged address, the command byte is acknowledged only when it equals C7h. A mismatching command byte is not acknowledged, the block returns to idle and nothing is written.
- R3: After an acknowledged command, the data byte is acknowledged only when it equals AAh. A mismatching data byte is not acknowledged and nothing is written.
- R4: The window is closed after the synchronous reset `rst_n`. A cycle with `link_reset` high opens it.
- R5: The window closes when any bit of `func_active` is 1 (the function is active) while `link_reset` is low. It stays closed when `func_active` returns to all zeros, until the next `link_reset`.
- R6: While the window is closed, no byte is acknowledged and no memory access is made.
- R7: A stop condition after an acknowledged data byte causes exactly one read and then exactly one write, both of word 12h. The write value is the read value with bits 15 and 14 cleared and bits 13..0 unchanged.
- R8: While an update is in progress, a new transaction's address byte is not acknowledged. A command sent during an update causes no extra memory access.
- R9: `clk_gate_req` is 1 exactly when the window is closed, no transaction is in progress and no update is in progress.
- R10: During and right after reset, `sda_pull_low` and `mem_req` are 0.
- R11: An accepted command leaves the window unchanged, so a later valid command inside the same window is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SMBus clock line |
| sda_in | input | 1 | Sampled SMBus data line |
| sda_pull_low | output | 1 | 1 pulls SDA low (acknowledge) |
| link_reset | input | 1 | Link reset seen; opens the window |
| func_active | input | NUM_FUNC | Per function: 1 = active, 0 = uninitialised |
| clk_gate_req | output | 1 | Responder idle with window closed |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Word address |
| mem_wdata | output | MEM_DW | Write data |
| mem_rdata | input | MEM_DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current access |

## Verification
The bench goes after byte mismatches at each of the three positions. A design that skipped a check would acknowledge a wrong code or write memory anyway. It also sends the read form of the correct address, which a design that ignored the direction bit would accept. The window is driven through its whole life: before any link reset, after a function becomes active, and after that function falls back to uninitialised. A design that reopened on the fall back would acknowledge a command. A second command is sent while a slow memory access is still pending, and a missing hold-off would show up as a second read-modify-write. Signature words whose low bits are all ones or mixed show whether the write clears only the top two bits.

// File: rtl/smbrec_pkg.sv
// Shared types for the SMBus recovery responder.
package smbrec_pkg;
    // Protocol position of the byte engine.
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_ADDR,
        ENG_CMD,
        ENG_DATA,
        ENG_DONE
    } eng_state_t;

    // Read-modify-write sequencer state.
    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_READ,
        UPD_WRITE
    } upd_state_t;
endpackage

// File: rtl/smbrec_line_sync.sv
// Synchronises SCL/SDA into clk and flags clock edges, start and stop.
// Assumes SMBus phases last several clk cycles; an idle bus reads high.
module smbrec_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbrec_window.sv
// Tracks the command window: opened by a link reset, closed for good once
// any function turns active. Assumes link_reset is synchronous to clk.
module smbrec_window #(
    parameter int NUM_FUNC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_reset,
    input  logic [NUM_FUNC-1:0] func_active,
    output logic                win_open
);
    // Window flag: reset closes, link reset opens, any active function closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_open <= 1'b0;
        else if (link_reset)
            win_open <= 1'b1;
        else if (|func_active)
            win_open <= 1'b0;
    end

    assert_reopen_only_by_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !link_reset) |=> !win_open);
    assert_open_on_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset |=> win_open);
endmodule

// File: rtl/smbrec_byte_engine.sv
// SMBus target byte engine for a Write Data Byte transaction. Shifts bits
// on SCL rise, decides ACK/NAK after the eighth bit and holds SDA low for
// the ninth clock. Pulses cmd_go on a stop that ends a complete command.
// Assumes the master changes SDA only while SCL is low except at start/stop.
module smbrec_byte_engine
    import smbrec_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h64,
    parameter logic [7:0] CMD_CODE    = 8'hC7,
    parameter logic [7:0] DATA_CODE   = 8'hAA
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    input  logic sda_bit,
    input  logic accept,
    output logic pull_low,
    output logic eng_idle,
    output logic cmd_go
);
    localparam logic [7:0] ADDR_BYTE = {TARGET_ADDR, 1'b0};

    eng_state_t state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       in_ack;
    logic [7:0] want;
    logic       byte_ok;

    // Expected byte for the current protocol position.
    always_comb begin
        case (state)
            ENG_ADDR: want = ADDR_BYTE;
            ENG_CMD:  want = CMD_CODE;
            default:  want = DATA_CODE;
        endcase
    end

    assign byte_ok  = accept && (shreg == want);
    assign eng_idle = (state == ENG_IDLE);

    // Protocol sequencing, bit shifting and ACK drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            pull_low <= 1'b0;
            cmd_go   <= 1'b0;
        end else begin
            cmd_go <= 1'b0;
            if (start_det) begin
                state    <= ENG_ADDR;
                bit_cnt  <= '0;
                in_ack   <= 1'b0;
                pull_low <= 1'b0;
            end else if (stop_det) begin
                cmd_go   <= (state == ENG_DONE);
                state    <= ENG_IDLE;
                in_ack   <= 1'b0;
                pull_low <= 1'b0;
            end else if (state != ENG_IDLE && state != ENG_DONE) begin
                if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
                    shreg   <= {shreg[6:0], sda_bit};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall && in_ack) begin
                    pull_low <= 1'b0;
                    in_ack   <= 1'b0;
                    bit_cnt  <= '0;
                    case (state)
                        ENG_ADDR: state <= ENG_CMD;
                        ENG_CMD:  state <= ENG_DATA;
                        default:  state <= ENG_DONE;
                    endcase
                end else if (scl_fall && bit_cnt == 4'd8) begin
                    if (byte_ok) begin
                        pull_low <= 1'b1;
                        in_ack   <= 1'b1;
                    end else begin
                        state   <= ENG_IDLE;
                        bit_cnt <= '0;
                    end
                end
            end
        end
    end

    assert_ack_only_in_xact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> !eng_idle);
    assert_go_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);
endmodule

// File: rtl/smbrec_updater.sv
// Read-modify-write of the signature word: one read, then one write with
// the two top bits cleared. The request is held until the memory acknowledges.
module smbrec_updater
    import smbrec_pkg::*;
#(
    parameter int              MEM_AW   = 6,
    parameter int              MEM_DW   = 16,
    parameter logic [MEM_AW-1:0] SIG_WORD = 6'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [MEM_DW-1:0] CLR_MASK = {2'b00, {(MEM_DW-2){1'b1}}};

    upd_state_t        state;
    logic [MEM_DW-1:0] held;

    // Sequencer: idle -> read -> write -> idle, each step on mem_ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= UPD_IDLE;
            held  <= '0;
        end else begin
            case (state)
                UPD_IDLE:  if (go) state <= UPD_READ;
                UPD_READ:  if (mem_ack) begin
                               held  <= mem_rdata & CLR_MASK;
                               state <= UPD_WRITE;
                           end
                default:   if (mem_ack) state <= UPD_IDLE;
            endcase
        end
    end

    assign busy      = (state != UPD_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state == UPD_WRITE);
    assign mem_addr  = SIG_WORD;
    assign mem_wdata = held;

    assert_write_clears_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[MEM_DW-1 -: 2] == 2'b00));
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
    assert_read_before_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_we);
endmodule

// File: rtl/smbus_recovery_responder.sv
// Top level: SMBus target that accepts the configuration-recovery command
// only inside the power window and then clears the signature bits in
// memory. Assumes an open-drain bus: sda_pull_low drives the line low.
module smbus_recovery_responder #(
    parameter int                NUM_FUNC    = 2,
    parameter int                MEM_AW      = 6,
    parameter int                MEM_DW      = 16,
    parameter logic [MEM_AW-1:0] SIG_WORD    = 6'h12,
    parameter logic [6:0]        TARGET_ADDR = 7'h64,
    parameter logic [7:0]        CMD_CODE    = 8'hC7,
    parameter logic [7:0]        DATA_CODE   = 8'hAA,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull_low,
    input  logic                link_reset,
    input  logic [NUM_FUNC-1:0] func_active,
    output logic                clk_gate_req,
    output logic                mem_req,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [MEM_DW-1:0]   mem_wdata,
    input  logic [MEM_DW-1:0]   mem_rdata,
    input  logic                mem_ack
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic win_open, eng_idle, cmd_go, upd_busy;

    smbrec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smbrec_window #(.NUM_FUNC(NUM_FUNC)) u_win (
        .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
        .func_active(func_active), .win_open(win_open)
    );

    smbrec_byte_engine #(
        .TARGET_ADDR(TARGET_ADDR), .CMD_CODE(CMD_CODE), .DATA_CODE(DATA_CODE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_in),
        .accept(win_open && !upd_busy), .pull_low(sda_pull_low),
        .eng_idle(eng_idle), .cmd_go(cmd_go)
    );

    smbrec_updater #(
        .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .SIG_WORD(SIG_WORD)
    ) u_upd (
        .clk(clk), .rst_n(rst_n), .go(cmd_go), .busy(upd_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign clk_gate_req = !win_open && eng_idle && !upd_busy;

    assert_no_ack_when_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> $past(win_open));
    assert_no_ack_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !$past(upd_busy));
    assert_gate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_req |-> (!sda_pull_low && !mem_req));
    assert_mem_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == SIG_WORD));
endmodule

// File: tb/tb_smbus_recovery_responder.sv
module tb_smbus_recovery_responder;
    localparam int H = 8;

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  c;
        logic [7:0]  d;
        logic [1:0]  acks;
        logic [15:0] init;
        logic [15:0] expw;
        logic        wr;
    } vec_t;

    // Vectors with the window open: R1 address, R2 command, R3 data, R7 result.
    localparam vec_t VECS [9] = '{
        '{8'hC8, 8'hC7, 8'hAA, 2'd3, 16'hFFFF, 16'h3FFF, 1'b1},
        '{8'hC9, 8'hC7, 8'hAA, 2'd0, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'hCA, 8'hC7, 8'hAA, 2'd0, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'hC8, 8'hC6, 8'hAA, 2'd1, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'hC8, 8'hC7, 8'hAB, 2'd2, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'hC8, 8'hC7, 8'hAA, 2'd3, 16'h4A5C, 16'h0A5C, 1'b1},
        '{8'h90, 8'hC7, 8'hAA, 2'd0, 16'h1234, 16'h1234, 1'b0},
        '{8'hC8, 8'hAA, 8'hC7, 2'd1, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'hC8, 8'hC7, 8'hAA, 2'd3, 16'hC000, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        link_reset = 1'b0;
    logic [1:0]  func_active = 2'b00;
    logic        sda_pull_low, clk_gate_req, mem_req, mem_we, mem_ack;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        sda_line;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] mem [64];
    int          n_wr = 0;
    int          n_rd = 0;
    int          lat_cnt = 0;
    int          mem_lat = 2;
    logic        preset_en = 1'b0;
    logic [15:0] preset_val = '0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    smbus_recovery_responder dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .link_reset(link_reset),
        .func_active(func_active), .clk_gate_req(clk_gate_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: fixed latency, one-cycle ack, counts reads and writes.
    initial mem_ack = 1'b0;
    initial mem_rdata = '0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (preset_en) mem[18] <= preset_val;
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= mem_lat) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    n_rd <= n_rd + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl_m = 1'b1; half();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        acked = !sda_line;
        scl_m = 1'b0; half();
    endtask

    task automatic xact(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                        output int acks);
        bit k;
        acks = 0;
        bus_start();
        send_byte(a, k);
        if (k) begin
            acks++;
            send_byte(c, k);
            if (k) begin
                acks++;
                send_byte(d, k);
                if (k) acks++;
            end
        end
        bus_stop();
    endtask

    task automatic preset(input logic [15:0] v);
        @(negedge clk); preset_val = v; preset_en = 1'b1;
        @(negedge clk); preset_en = 1'b0;
    endtask

    task automatic pulse_link();
        @(negedge clk); link_reset = 1'b1;
        @(negedge clk); link_reset = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int acks, wr0, rd0;
        bit k;

        // R10 reset state; R4 window closed after reset (gate request high, R9).
        repeat (4) @(negedge clk);
        check("R10", "sda_pull_low in reset", sda_pull_low, 0);
        check("R10", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "sda_pull_low after reset", sda_pull_low, 0);
        check("R4", "clk_gate_req window closed after reset", clk_gate_req, 1);

        // R6: a valid command before any link reset is ignored.
        preset(16'hFFFF);
        wr0 = n_wr; rd0 = n_rd;
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        repeat (30) @(negedge clk);
        check("R6", "acks with window closed", acks, 0);
        check("R6", "accesses with window closed", (n_wr - wr0) + (n_rd - rd0), 0);

        // R4: link reset opens the window.
        pulse_link();
        @(negedge clk);
        check("R4", "clk_gate_req after link reset", clk_gate_req, 0);

        // Table walk; repeated acceptance in one window covers R11.
        foreach (VECS[i]) begin
            preset(VECS[i].init);
            wr0 = n_wr; rd0 = n_rd;
            xact(VECS[i].a, VECS[i].c, VECS[i].d, acks);
            repeat (30) @(negedge clk);
            check("R1/R2/R3", $sformatf("vector %0d ack count", i), acks, VECS[i].acks);
            check("R7", $sformatf("vector %0d writes", i), n_wr - wr0, VECS[i].wr);
            check("R7", $sformatf("vector %0d reads", i), n_rd - rd0, VECS[i].wr);
            check("R7", $sformatf("vector %0d word 12h", i), mem[18], VECS[i].expw);
        end
        check("R11", "window still open after commands", clk_gate_req, 0);

        // R8: command during a slow update is refused.
        mem_lat = 600;
        preset(16'hFFFF);
        wr0 = n_wr; rd0 = n_rd;
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        check("R8", "first command acks", acks, 3);
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        check("R8", "address ack while busy", acks, 0);
        repeat (1500) @(negedge clk);
        check("R8", "writes after busy attempt", n_wr - wr0, 1);
        check("R8", "reads after busy attempt", n_rd - rd0, 1);
        check("R7", "word after busy test", mem[18], 16'h3FFF);
        mem_lat = 2;

        // R5: a function turning active closes the window.
        @(negedge clk); func_active = 2'b10;
        repeat (3) @(negedge clk);
        check("R9", "clk_gate_req once closed", clk_gate_req, 1);
        preset(16'hFFFF);
        wr0 = n_wr;
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        repeat (30) @(negedge clk);
        check("R5", "acks after function active", acks, 0);
        check("R6", "writes after function active", n_wr - wr0, 0);

        // R5: falling back to uninitialised does not reopen.
        func_active = 2'b00;
        repeat (3) @(negedge clk);
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        repeat (30) @(negedge clk);
        check("R5", "acks after fall back", acks, 0);
        check("R5", "word unchanged after fall back", mem[18], 16'hFFFF);

        // R9: a transaction in progress drops the gate request.
        bus_start();
        check("R9", "clk_gate_req during transaction", clk_gate_req, 0);
        send_byte(8'hC8, k);
        check("R6", "address ack window closed", int'(k), 0);
        bus_stop();
        repeat (5) @(negedge clk);
        check("R9", "clk_gate_req after NAKed transaction", clk_gate_req, 1);

        // R4: a new link reset reopens the window.
        pulse_link();
        xact(8'hC8, 8'hC7, 8'hAA, acks);
        repeat (30) @(negedge clk);
        check("R4", "acks after second link reset", acks, 3);
        check("R7", "word after reopen", mem[18], 16'h3FFF);

        // R4: synchronous reset closes the window again.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4", "clk_gate_req after reset", clk_gate_req, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule